// File: doc/BRIEF.md
# Flash Ready/Busy Status Tracker

This block follows the ready/busy condition of an on-chip flash that runs its own embedded program and erase algorithms. It watches the bus writes aimed at the flash address space and recognises command sequences. Each sequence is two key writes followed by a command-code write. When the last write of a sequence lands, the block declares the flash busy and starts a modelled engine. The engine answers later with a done or a fail pulse.

The ready/busy state is visible in two places. A host can watch a dedicated output pin. Software can read one 32-bit control/status word that is mapped at a parameterised address. Block erase is handled differently from the other commands: it opens a time-out window, and every further block-select write restarts that window. The flash becomes busy only when the window runs out. A failed operation leaves the flash busy until a hardware reset. A build-time option models a mask-ROM part. In that part the status word is fixed and no command is recognised.

Top module: `flash_rdy_tracker`

## Requirements
- R1: After a synchronous reset, `rdy_pin` is 1 and a read of the status word returns 0x00000001: ready bit (bit 0) set, mask bit (bit 2) clear.
- R2: A chip-erase sequence (0xAA to KEY_ADDR1, 0x55 to KEY_ADDR2, 0x10 to KEY_ADDR1) makes the flash busy on the edge that samples the code write. A program sequence (code 0xA0) makes it busy only on the edge that samples the following data write. On that same edge `eng_start` pulses for one cycle, with `eng_cmd` = 1 for program and 2 for chip erase.
- R3: A block-erase code write (0x30) leaves the flash ready for TMO_CYC edges. It becomes busy on the TMO_CYC-th edge after the last flash write of value 0x30, because each such write during the window restarts the count. At that point `eng_start` pulses with `eng_cmd` = 3.
- R4: While the flash is busy, flash writes are ignored and do not advance the sequence detector. A lone code write made after ready returns starts nothing.
- R5: An `eng_done` pulse while busy (and not failed) returns the flash to ready on the next edge.
- R6: An `eng_fail` pulse while busy keeps the flash busy permanently. Later `eng_done` pulses and commands have no effect, and only reset restores ready.
- R7: A write to the status word takes effect only when all four byte enables are set. Only bit 2 (mask bit) is writable. The ready bit and all other bits ignore writes.
- R8: A status read returns the ready state in bit 0, the mask bit in bit 2 and 0 in every other bit. `bus_rdata` is 0 when no status read is made.
- R9: `rdy_pin` always equals the ready bit of the status word.
- R10: With MASK_ROM=1 the status word always reads 0x00000005, writes have no effect, no command is recognised and `rdy_pin` stays 1.
- R11: A key write with wrong data or to the wrong address returns the detector to idle, so a later code write alone does not start an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Access address |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data (combinational) |
| eng_done | input | 1 | Engine finished successfully |
| eng_fail | input | 1 | Engine reported failure |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_cmd | output | 2 | Operation code of the last start (1 program, 2 chip erase, 3 block erase) |
| rdy_pin | output | 1 | External ready/busy level (1 = ready) |

## Verification
The hardest situation to reach is a block-erase window that is restarted late, close to its expiry. The bench issues the erase code and waits TMO_CYC-2 idle cycles. It then writes a further block select and checks two things: ready still holds one edge before the restarted count ends, and busy appears on the exact edge where the new count ends. The stuck-busy state is also checked. A done pulse and fresh command writes are given after a failure, and the bench confirms that only reset clears it. A reference model in the bench, run in step every cycle, covers the interleavings between these directed points.

// File: rtl/flrb_pkg.sv
package flrb_pkg;

    localparam int RDY_BIT  = 0;
    localparam int MASK_BIT = 2;

    localparam logic [31:0] KEY_WORD1  = 32'h0000_00AA;
    localparam logic [31:0] KEY_WORD2  = 32'h0000_0055;
    localparam logic [31:0] CODE_PROG  = 32'h0000_00A0;
    localparam logic [31:0] CODE_CHIP  = 32'h0000_0010;
    localparam logic [31:0] CODE_BLOCK = 32'h0000_0030;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_KEY1,
        SQ_KEY2,
        SQ_PDATA,
        SQ_EWIN
    } seq_st_t;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_PROG  = 2'd1,
        OP_CHIP  = 2'd2,
        OP_BLOCK = 2'd3
    } op_t;

    typedef struct packed {
        logic valid;
        op_t  op;
    } launch_t;

    function automatic logic [31:0] status_image(input logic rdy, input logic mbit);
        logic [31:0] img;
        img           = '0;
        img[RDY_BIT]  = rdy;
        img[MASK_BIT] = mbit;
        return img;
    endfunction

endpackage

// File: rtl/flrb_seq.sv
module flrb_seq
    import flrb_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] KEY_ADDR1 = 16'h0AAA,
    parameter logic [ADDR_W-1:0] KEY_ADDR2 = 16'h0555,
    parameter int              TMO_CYC   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flash_wr,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_word,
    input  logic              ready,
    output launch_t           launch
);
    localparam int CNT_W = $clog2(TMO_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TMO_CYC - 1);

    seq_st_t          st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        launch = '{valid: 1'b0, op: OP_NONE};
        if (ready) begin
            case (st_q)
                SQ_IDLE: begin
                    if (flash_wr && wr_addr == KEY_ADDR1 && wr_word == KEY_WORD1)
                        st_d = SQ_KEY1;
                end
                SQ_KEY1: begin
                    if (flash_wr)
                        st_d = (wr_addr == KEY_ADDR2 && wr_word == KEY_WORD2) ? SQ_KEY2 : SQ_IDLE;
                end
                SQ_KEY2: begin
                    if (flash_wr) begin
                        st_d = SQ_IDLE;
                        if (wr_addr == KEY_ADDR1) begin
                            if (wr_word == CODE_PROG) begin
                                st_d = SQ_PDATA;
                            end else if (wr_word == CODE_CHIP) begin
                                launch = '{valid: 1'b1, op: OP_CHIP};
                            end else if (wr_word == CODE_BLOCK) begin
                                st_d  = SQ_EWIN;
                                cnt_d = CNT_LOAD;
                            end
                        end
                    end
                end
                SQ_PDATA: begin
                    if (flash_wr) begin
                        st_d   = SQ_IDLE;
                        launch = '{valid: 1'b1, op: OP_PROG};
                    end
                end
                SQ_EWIN: begin
                    if (flash_wr && wr_word == CODE_BLOCK) begin
                        cnt_d = CNT_LOAD;
                    end else if (cnt_q == '0) begin
                        st_d   = SQ_IDLE;
                        launch = '{valid: 1'b1, op: OP_BLOCK};
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                default: st_d = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SQ_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // R4
    busy_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        !ready |=> $stable(st_q));

    // R3
    window_launch_chk: assert property (@(posedge clk) disable iff (rst)
        (launch.valid && launch.op == OP_BLOCK) |-> $past(st_q) == SQ_EWIN || st_q == SQ_EWIN);

endmodule

// File: rtl/flrb_state.sv
module flrb_state
    import flrb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  launch_t launch,
    input  logic    eng_done,
    input  logic    eng_fail,
    output logic    rdy,
    output logic    start,
    output op_t     op
);
    logic rdy_q, failed_q, start_q;
    op_t  op_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_q    <= 1'b1;
            failed_q <= 1'b0;
            start_q  <= 1'b0;
            op_q     <= OP_NONE;
        end else begin
            start_q <= 1'b0;
            if (launch.valid && rdy_q) begin
                rdy_q   <= 1'b0;
                start_q <= 1'b1;
                op_q    <= launch.op;
            end else if (!rdy_q && !failed_q) begin
                if (eng_fail)
                    failed_q <= 1'b1;
                else if (eng_done)
                    rdy_q <= 1'b1;
            end
        end
    end

    assign rdy   = rdy_q;
    assign start = start_q;
    assign op    = op_q;

    // R6
    fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        failed_q |=> failed_q && !rdy_q);

    // R2
    launch_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (launch.valid && rdy_q) |=> (!rdy_q && start_q));

    // R5
    ready_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (!rdy_q ##1 rdy_q) |-> $past(eng_done));

endmodule

// File: rtl/flrb_csr.sv
module flrb_csr
    import flrb_pkg::*;
#(
    parameter bit MASK_ROM = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_hit,
    input  logic [3:0]  wr_be,
    input  logic        wr_mbit,
    input  logic        rd_hit,
    input  logic        rdy,
    output logic [31:0] rdata
);
    logic mbit;

    generate
        if (MASK_ROM) begin : g_mask
            assign mbit = 1'b1;
        end else begin : g_flash
            logic mbit_q;
            always_ff @(posedge clk) begin
                if (rst)
                    mbit_q <= 1'b0;
                else if (wr_hit && wr_be == 4'hF)
                    mbit_q <= wr_mbit;
            end
            assign mbit = mbit_q;

            // R7
            partial_write_chk: assert property (@(posedge clk) disable iff (rst)
                (wr_hit && wr_be != 4'hF) |=> $stable(mbit_q));
        end
    endgenerate

    assign rdata = rd_hit ? status_image(MASK_ROM ? 1'b1 : rdy, mbit) : 32'h0;

endmodule

// File: rtl/flash_rdy_tracker.sv
module flash_rdy_tracker
    import flrb_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CSR_ADDR  = 16'hFF00,
    parameter logic [ADDR_W-1:0] KEY_ADDR1 = 16'h0AAA,
    parameter logic [ADDR_W-1:0] KEY_ADDR2 = 16'h0555,
    parameter int                TMO_CYC   = 16,
    parameter bit                MASK_ROM  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [3:0]        bus_be,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [31:0]       bus_rdata,
    input  logic              eng_done,
    input  logic              eng_fail,
    output logic              eng_start,
    output logic [1:0]        eng_cmd,
    output logic              rdy_pin
);
    logic    csr_sel, flash_wr, rd_hit, wr_hit, rdy;
    launch_t launch;
    op_t     op;

    assign csr_sel  = (bus_addr == CSR_ADDR);
    assign flash_wr = bus_we && !csr_sel;
    assign wr_hit   = bus_we && csr_sel;
    assign rd_hit   = bus_re && csr_sel;

    generate
        if (MASK_ROM) begin : g_no_seq
            assign launch = '{valid: 1'b0, op: OP_NONE};
        end else begin : g_seq
            flrb_seq #(
                .ADDR_W    (ADDR_W),
                .KEY_ADDR1 (KEY_ADDR1),
                .KEY_ADDR2 (KEY_ADDR2),
                .TMO_CYC   (TMO_CYC)
            ) seq_i (
                .clk      (clk),
                .rst      (rst),
                .flash_wr (flash_wr),
                .wr_addr  (bus_addr),
                .wr_word  (bus_wdata),
                .ready    (rdy),
                .launch   (launch)
            );
        end
    endgenerate

    flrb_state state_i (
        .clk      (clk),
        .rst      (rst),
        .launch   (launch),
        .eng_done (eng_done),
        .eng_fail (eng_fail),
        .rdy      (rdy),
        .start    (eng_start),
        .op       (op)
    );

    flrb_csr #(.MASK_ROM(MASK_ROM)) csr_i (
        .clk     (clk),
        .rst     (rst),
        .wr_hit  (wr_hit),
        .wr_be   (bus_be),
        .wr_mbit (bus_wdata[MASK_BIT]),
        .rd_hit  (rd_hit),
        .rdy     (rdy),
        .rdata   (bus_rdata)
    );

    assign eng_cmd = op;
    assign rdy_pin = rdy;

    // R9
    pin_read_chk: assert property (@(posedge clk) disable iff (rst)
        rd_hit |-> bus_rdata[RDY_BIT] == rdy_pin);

endmodule

// File: tb/flash_rdy_tracker_tb.sv
module flash_rdy_tracker_tb_top;

    localparam int          TMO  = 6;
    localparam logic [15:0] CSR  = 16'hFF00;
    localparam logic [15:0] K1   = 16'h0AAA;
    localparam logic [15:0] K2   = 16'h0555;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic        eng_done = 1'b0;
    logic        eng_fail = 1'b0;
    logic [31:0] bus_rdata, rdata_m;
    logic        eng_start, rdy_pin, start_m, rdy_m;
    logic [1:0]  eng_cmd, cmd_m;

    int total = 0;
    int bad   = 0;
    bit fin   = 1'b0;

    always #10 clk = ~clk;

    flash_rdy_tracker #(.TMO_CYC(TMO)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_be(bus_be), .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .eng_done(eng_done), .eng_fail(eng_fail), .eng_start(eng_start),
        .eng_cmd(eng_cmd), .rdy_pin(rdy_pin));

    flash_rdy_tracker #(.TMO_CYC(TMO), .MASK_ROM(1'b1)) dut_mask (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_be(bus_be), .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(rdata_m),
        .eng_done(eng_done), .eng_fail(eng_fail), .eng_start(start_m),
        .eng_cmd(cmd_m), .rdy_pin(rdy_m));

    // behavioural reference model
    int m_rdy = 1, m_fail = 0, m_ph = 0, m_cnt = 0, m_mb = 0, m_start = 0, m_op = 0;

    always @(posedge clk) begin
        bit fw, go;
        int gop;
        logic [31:0] d;
        if (rst) begin
            m_rdy = 1; m_fail = 0; m_ph = 0; m_cnt = 0; m_mb = 0; m_start = 0; m_op = 0;
        end else begin
            fw = bus_we && (bus_addr != CSR);
            d  = bus_wdata;
            go = 1'b0; gop = 0;
            if (m_rdy == 1) begin
                if (m_ph == 0) begin
                    if (fw && bus_addr == K1 && d == 32'hAA) m_ph = 1;
                end else if (m_ph == 1) begin
                    if (fw) m_ph = (bus_addr == K2 && d == 32'h55) ? 2 : 0;
                end else if (m_ph == 2) begin
                    if (fw) begin
                        m_ph = 0;
                        if (bus_addr == K1) begin
                            if (d == 32'hA0) m_ph = 3;
                            else if (d == 32'h10) begin go = 1; gop = 2; end
                            else if (d == 32'h30) begin m_ph = 4; m_cnt = TMO - 1; end
                        end
                    end
                end else if (m_ph == 3) begin
                    if (fw) begin m_ph = 0; go = 1; gop = 1; end
                end else begin
                    if (fw && d == 32'h30) m_cnt = TMO - 1;
                    else if (m_cnt == 0) begin go = 1; gop = 3; m_ph = 0; end
                    else m_cnt = m_cnt - 1;
                end
            end
            m_start = 0;
            if (go) begin
                m_rdy = 0; m_start = 1; m_op = gop;
            end else if (m_rdy == 0 && m_fail == 0) begin
                if (eng_fail) m_fail = 1;
                else if (eng_done) m_rdy = 1;
            end
            if (bus_we && bus_addr == CSR && bus_be == 4'hF) m_mb = int'(bus_wdata[2]);
        end
    end

    task automatic dchk(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always begin
        logic [31:0] exp_rd, exp_rm;
        @(negedge clk);
        #5;
        if (!rst && !fin) begin
            exp_rd = (bus_re && bus_addr == CSR) ?
                     {29'b0, m_mb[0], 1'b0, m_rdy[0]} : 32'h0;
            exp_rm = (bus_re && bus_addr == CSR) ? 32'h5 : 32'h0;
            dchk("R9 pin", {31'b0, rdy_pin}, {31'b0, m_rdy[0]});
            dchk("R8 rdata", bus_rdata, exp_rd);
            dchk("R2 start", {31'b0, eng_start}, {31'b0, m_start[0]});
            if (m_start == 1) dchk("R2 cmd", {30'b0, eng_cmd}, 32'(m_op));
            dchk("R10 mask pin", {31'b0, rdy_m}, 32'h1);
            dchk("R10 mask rdata", rdata_m, exp_rm);
            dchk("R10 mask start", {31'b0, start_m}, 32'h0);
        end
    end

    task automatic drive(bit we, logic [15:0] a, logic [31:0] d, logic [3:0] be, bit re,
                         bit dn, bit fl);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d; bus_be = be; bus_re = re;
        eng_done = dn; eng_fail = fl;
    endtask

    task automatic fwr(logic [15:0] a, logic [31:0] d);
        drive(1'b1, a, d, 4'hF, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic nop(int n);
        repeat (n) drive(1'b0, '0, '0, '0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic pin_chk(string req, logic exp);
        nop(1);
        #5;
        dchk(req, {31'b0, rdy_pin}, {31'b0, exp});
    endtask

    task automatic rd_chk(string req, logic [31:0] exp);
        drive(1'b0, CSR, '0, '0, 1'b1, 1'b0, 1'b0);
        #5;
        dchk(req, bus_rdata, exp);
    endtask

    task automatic unlock();
        fwr(K1, 32'hAA);
        fwr(K2, 32'h55);
    endtask

    task automatic finish_op();
        drive(1'b0, '0, '0, '0, 1'b0, 1'b1, 1'b0);
        nop(1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        pin_chk("R1 reset pin", 1'b1);
        rd_chk("R1 reset read", 32'h1);
        drive(1'b0, CSR, '0, '0, 1'b1, 1'b0, 1'b0);
        #5 dchk("R10 mask read", rdata_m, 32'h5);
        drive(1'b0, CSR, '0, '0, 1'b0, 1'b0, 1'b0);
        #5 dchk("R8 no read gives 0", bus_rdata, 32'h0);

        // R2 chip erase, busy on code write
        unlock();
        pin_chk("R2 ready before code", 1'b1);
        fwr(K1, 32'h10);
        #5 dchk("R2 ready until code edge", {31'b0, rdy_pin}, 32'h1);
        pin_chk("R2 chip busy", 1'b0);
        // R4 writes while busy are ignored
        unlock();
        fwr(K1, 32'h10);
        pin_chk("R4 busy holds", 1'b0);
        finish_op();
        #5 dchk("R5 done returns ready", {31'b0, rdy_pin}, 32'h1);
        fwr(K1, 32'h10);
        pin_chk("R4 detector not advanced", 1'b1);

        // R2 program, busy on data write
        unlock();
        fwr(K1, 32'hA0);
        pin_chk("R2 program waits data", 1'b1);
        fwr(16'h1234, 32'hDEAD_BEEF);
        pin_chk("R2 program busy", 1'b0);
        finish_op();

        // R3 block erase window
        unlock();
        fwr(K1, 32'h30);
        nop(TMO - 1);
        pin_chk("R3 ready in window", 1'b1);
        pin_chk("R3 busy at expiry", 1'b0);
        finish_op();
        unlock();
        fwr(K1, 32'h30);
        nop(TMO - 2);
        fwr(16'h2000, 32'h30);
        nop(TMO - 1);
        pin_chk("R3 restart extends window", 1'b1);
        pin_chk("R3 busy after restart", 1'b0);
        finish_op();

        // R11 broken sequence
        fwr(K1, 32'hAA);
        fwr(K2, 32'h56);
        fwr(K1, 32'h10);
        pin_chk("R11 bad key drops", 1'b1);
        fwr(K1, 32'hAA);
        fwr(K1, 32'h55);
        fwr(K1, 32'h10);
        pin_chk("R11 bad addr drops", 1'b1);

        // R7 / R8 register access
        drive(1'b1, CSR, 32'hFFFF_FFFF, 4'hF, 1'b0, 1'b0, 1'b0);
        rd_chk("R7 only bit2 writable", 32'h5);
        drive(1'b1, CSR, 32'h0, 4'h7, 1'b0, 1'b0, 1'b0);
        rd_chk("R7 partial write ignored", 32'h5);
        drive(1'b1, CSR, 32'h0, 4'hF, 1'b0, 1'b0, 1'b0);
        rd_chk("R7 full write clears", 32'h1);
        unlock();
        fwr(K1, 32'h10);
        rd_chk("R8 busy read", 32'h0);
        drive(1'b0, CSR, '0, '0, 1'b1, 1'b0, 1'b0);
        #5 dchk("R10 mask unaffected", rdata_m, 32'h5);

        // R6 failure sticks
        drive(1'b0, '0, '0, '0, 1'b0, 1'b0, 1'b1);
        pin_chk("R6 fail busy", 1'b0);
        finish_op();
        nop(10);
        unlock();
        fwr(K1, 32'h10);
        pin_chk("R6 stuck after done", 1'b0);
        rst = 1'b1;
        nop(2);
        rst = 1'b0;
        pin_chk("R6 reset recovers", 1'b1);
        nop(2);

        fin = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!fin) begin
            fin = 1'b1;
            total++;
            bad++;
            $display("FAIL R1 watchdog got=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule